// File: doc/BRIEF.md
# Handshake Bus Memory Slave

This block is a slave on a master/slave handshake bus that uses 18-bit byte addresses and a 16-bit data path. It holds a small array of 16-bit words. The array occupies an aligned address window whose position is set by a parameter. When the master raises its sync strobe, the slave checks the address against its window. It then decodes a two-bit cycle code and carries out the transfer against its word array. It answers with its own sync strobe, which stays high until the master lets go.

The block supports four cycle types:

- a plain word read
- a read that opens a read-modify-write sequence
- a full-word write
- a single-byte write

A read-modify-write read locks the addressed word until a later write to that word completes the sequence. A second read-modify-write read aimed at the locked word is held off until the lock is released. Two power-warning inputs from the supply block every write while either of them is high. The slave still acknowledges those writes, so the master does not hang. A bus-wide init input drops any pending lock.

All bus inputs are assumed to have been brought into the `clk` domain before they reach this block.

Top module: `hsb_slave`

## Requirements
- R1: Cycle code 00 is a word read: once slave sync is high, `rdata` holds the addressed word.
- R2: Cycle code 10 is a word write: all 16 bits of `wdata` replace the addressed word.
- R3: Cycle code 11 is a byte write. With address bit 0 at 0, `wdata[7:0]` replaces bits 7:0 of the addressed word. With bit 0 at 1, `wdata[15:8]` replaces bits 15:8. The other byte keeps its value.
- R4: The word index is taken from address bits 3:1 (default 8 words). An address whose bits 17:4 differ from those of `BASE_ADDR` gets no slave sync and changes no word.
- R5: Slave sync goes high in the cycle after the clock edge that sees master sync rise with a matching address. It stays high while master sync stays high, and it goes low in the cycle after master sync falls.
- R6: Cycle code 01 returns the addressed word like a read and locks that word. A later word write or byte write to the same word completes the sequence and releases the lock.
- R7: A code-01 cycle that targets the locked word gets no slave sync until the lock is released.
- R8: While `ac_low` or `dc_low` is high, write cycles are still acknowledged but leave every stored word unchanged.
- R9: `bus_init` clears the lock. A code-01 cycle that was held off then completes and is acknowledged.
- R10: After reset, slave sync is low, `rdata` is zero and every stored word is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_init | input | 1 | Bus-wide init; clears the read-modify-write lock |
| ac_low | input | 1 | Supply warning: AC input failing |
| dc_low | input | 1 | Supply warning: DC output failing |
| msync | input | 1 | Master sync strobe |
| addr | input | 18 | Byte address |
| ctl | input | 2 | Cycle code (00 read, 01 read-with-pause, 10 word write, 11 byte write) |
| wdata | input | 16 | Write data from master |
| rdata | output | 16 | Read data to master, valid while slave sync is high |
| ssync | output | 1 | Slave sync strobe |

## Verification
The main function is driven through a vector table of cycles that mixes the four codes:

- Word writes followed by reads show that stored values are kept separate per word.
- Byte writes on both lanes, each read back, tell the low lane apart from the high lane and confirm that the untouched byte survives.
- An address outside the window, followed by a read of a word inside it, separates ignoring a cycle from aliasing onto the array.
- A read-with-pause, its completing write and a second read-with-pause to the same word show that a completed sequence unlocks.

Directed cases cover three more situations:

- A read-with-pause held off by a lock and then freed by `bus_init`.
- Writes under each power warning, read back afterwards to confirm the word is unchanged.
- The strobe timing while master sync is held high across several cycles.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 16;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        CYC_READ       = 2'b00,
        CYC_READ_PAUSE = 2'b01,
        CYC_WRITE_WORD = 2'b10,
        CYC_WRITE_BYTE = 2'b11
    } cyc_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_ACK  = 2'd2
    } hs_state_e;

    typedef struct packed {
        cyc_e              cyc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic cyc_is_write(cyc_e c);
        return c == CYC_WRITE_WORD || c == CYC_WRITE_BYTE;
    endfunction

    function automatic logic cyc_is_rmw(cyc_e c);
        return c == CYC_READ_PAUSE;
    endfunction

    // Lane enables: bit 0 covers data bits 7:0, bit 1 covers data bits 15:8.
    function automatic logic [LANES-1:0] lane_mask(cyc_e c, logic hi_lane);
        logic [LANES-1:0] m;
        m = '0;
        if (c == CYC_WRITE_WORD) begin
            m = '1;
        end else if (c == CYC_WRITE_BYTE) begin
            m = hi_lane ? LANES'(2'b10) : LANES'(2'b01);
        end
        return m;
    endfunction

endpackage

// File: rtl/hsb_decode.sv
module hsb_decode
    import hsb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BASE_ADDR = 18'h3FF00,
    parameter int                WORDS     = 8,
    localparam int               IDX_W     = $clog2(WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output logic              hi_lane
);
    localparam int TAG_LO = IDX_W + 1;

    always_comb begin
        hit     = addr[ADDR_W-1:TAG_LO] == BASE_ADDR[ADDR_W-1:TAG_LO];
        idx     = addr[IDX_W:1];
        hi_lane = addr[0];
    end

endmodule

// File: rtl/hsb_regfile.sv
module hsb_regfile
    import hsb_pkg::*;
#(
    parameter int  WORDS = 8,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [IDX_W-1:0]        idx,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W-1:0]       rd_word,
    output logic [WORDS*DATA_W-1:0] store_view
);
    logic [DATA_W-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst) begin
                    words[w][b*8 +: 8] <= '0;
                end else if (wr_lanes[b] && idx == IDX_W'(w)) begin
                    words[w][b*8 +: 8] <= wdata[b*8 +: 8];
                end
            end
        end
        assign store_view[w*DATA_W +: DATA_W] = words[w];
    end

    assign rd_word = words[idx];

endmodule

// File: rtl/hsb_lock.sv
module hsb_lock #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_init,
    input  logic             set_lock,
    input  logic             wr_done,
    input  logic [IDX_W-1:0] idx,
    output logic             blocked,
    output logic             lock_valid
);
    logic [IDX_W-1:0] lock_idx;

    always_ff @(posedge clk) begin
        if (rst || bus_init) begin
            lock_valid <= 1'b0;
            lock_idx   <= '0;
        end else if (set_lock) begin
            lock_valid <= 1'b1;
            lock_idx   <= idx;
        end else if (wr_done && lock_valid && lock_idx == idx) begin
            lock_valid <= 1'b0;
        end
    end

    assign blocked = lock_valid && lock_idx == idx;

endmodule

// File: rtl/hsb_handshake.sv
module hsb_handshake
    import hsb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic msync,
    input  logic hit,
    input  logic is_rmw,
    input  logic blocked,
    output logic fire,
    output logic ssync
);
    hs_state_e state, state_nx;
    logic      msync_q;
    logic      start;

    assign start = msync && !msync_q && hit;

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (is_rmw && blocked) begin
                        state_nx = ST_HOLD;
                    end else begin
                        fire     = 1'b1;
                        state_nx = ST_ACK;
                    end
                end
            end
            ST_HOLD: begin
                if (!msync) begin
                    state_nx = ST_IDLE;
                end else if (!blocked) begin
                    fire     = 1'b1;
                    state_nx = ST_ACK;
                end
            end
            ST_ACK: begin
                if (!msync) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            msync_q <= 1'b0;
        end else begin
            state   <= state_nx;
            msync_q <= msync;
        end
    end

    assign ssync = state == ST_ACK;

endmodule

// File: rtl/hsb_slave.sv
module hsb_slave
    import hsb_pkg::*;
#(
    parameter logic [17:0] BASE_ADDR = 18'h3FF00,
    parameter int          WORDS     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_init,
    input  logic        ac_low,
    input  logic        dc_low,
    input  logic        msync,
    input  logic [17:0] addr,
    input  logic [1:0]  ctl,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        ssync
);
    localparam int IDX_W = $clog2(WORDS);

    bus_req_t                req;
    logic                    hit, hi_lane, fire, blocked, lock_valid, power_fail;
    logic [IDX_W-1:0]        idx;
    logic [LANES-1:0]        wr_lanes;
    logic [DATA_W-1:0]       rd_word;
    logic [DATA_W-1:0]       rdata_q;
    logic [WORDS*DATA_W-1:0] store_view;

    assign req.cyc   = cyc_e'(ctl);
    assign req.addr  = addr;
    assign req.wdata = wdata;

    assign power_fail = ac_low || dc_low;

    hsb_decode #(.BASE_ADDR(BASE_ADDR), .WORDS(WORDS)) u_decode (
        .addr    (req.addr),
        .hit     (hit),
        .idx     (idx),
        .hi_lane (hi_lane)
    );

    hsb_handshake u_hs (
        .clk     (clk),
        .rst     (rst),
        .msync   (msync),
        .hit     (hit),
        .is_rmw  (cyc_is_rmw(req.cyc)),
        .blocked (blocked),
        .fire    (fire),
        .ssync   (ssync)
    );

    assign wr_lanes = (fire && !power_fail) ? lane_mask(req.cyc, hi_lane) : '0;

    hsb_regfile #(.WORDS(WORDS)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_lanes   (wr_lanes),
        .idx        (idx),
        .wdata      (req.wdata),
        .rd_word    (rd_word),
        .store_view (store_view)
    );

    hsb_lock #(.IDX_W(IDX_W)) u_lock (
        .clk        (clk),
        .rst        (rst),
        .bus_init   (bus_init),
        .set_lock   (fire && cyc_is_rmw(req.cyc)),
        .wr_done    (fire && cyc_is_write(req.cyc)),
        .idx        (idx),
        .blocked    (blocked),
        .lock_valid (lock_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (fire && !cyc_is_write(req.cyc)) begin
            rdata_q <= rd_word;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/hsb_slave_checker.sv
module hsb_slave_checker #(
    parameter int WORDS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_init,
    input logic                ac_low,
    input logic                dc_low,
    input logic                msync,
    input logic                ssync,
    input logic                lock_valid,
    input logic [WORDS*16-1:0] store_view
);
    // R5: once acknowledged, slave sync holds until master sync falls
    a_r5_ssync_hold: assert property (@(posedge clk) disable iff (rst)
        (ssync && msync) |=> ssync);

    // R5: no acknowledge appears while master sync is low
    a_r5_no_spontaneous_ack: assert property (@(posedge clk) disable iff (rst)
        (!msync && !ssync) |=> !ssync);

    // R5: a rising slave sync follows a cycle in which master sync was high
    a_r5_ack_after_msync: assert property (@(posedge clk) disable iff (rst)
        $rose(ssync) |-> $past(msync));

    // R8: a power warning freezes the storage
    a_r8_pf_store_stable: assert property (@(posedge clk) disable iff (rst)
        (ac_low || dc_low) |=> $stable(store_view));

    // R9: bus init drops the lock
    a_r9_init_clears_lock: assert property (@(posedge clk) disable iff (rst)
        bus_init |=> !lock_valid);

endmodule

bind hsb_slave hsb_slave_checker #(.WORDS(WORDS)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .bus_init   (bus_init),
    .ac_low     (ac_low),
    .dc_low     (dc_low),
    .msync      (msync),
    .ssync      (ssync),
    .lock_valid (lock_valid),
    .store_view (store_view)
);

// File: tb/hsb_slave_tb_top.sv
module hsb_slave_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_init = 1'b0;
    logic        ac_low = 1'b0;
    logic        dc_low = 1'b0;
    logic        msync = 1'b0;
    logic [17:0] addr = '0;
    logic [1:0]  ctl = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ssync;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    hsb_slave dut_i (
        .clk      (clk),
        .rst      (rst),
        .bus_init (bus_init),
        .ac_low   (ac_low),
        .dc_low   (dc_low),
        .msync    (msync),
        .addr     (addr),
        .ctl      (ctl),
        .wdata    (wdata),
        .rdata    (rdata),
        .ssync    (ssync)
    );

    // Vector fields: ctl[53:52] addr[51:34] wdata[33:18] exp_ack[17] chk_rd[16] exp_rd[15:0]
    localparam int NV = 14;
    localparam logic [53:0] VECS [NV] = '{
        {2'b10, 18'h3FF00, 16'h1234, 1'b1, 1'b0, 16'h0000},  // R2 word write
        {2'b00, 18'h3FF00, 16'h0000, 1'b1, 1'b1, 16'h1234},  // R1 read back
        {2'b10, 18'h3FF02, 16'hABCD, 1'b1, 1'b0, 16'h0000},  // R2
        {2'b11, 18'h3FF02, 16'hEE55, 1'b1, 1'b0, 16'h0000},  // R3 low lane
        {2'b00, 18'h3FF02, 16'h0000, 1'b1, 1'b1, 16'hAB55},  // R3
        {2'b11, 18'h3FF03, 16'h6677, 1'b1, 1'b0, 16'h0000},  // R3 high lane
        {2'b00, 18'h3FF03, 16'h0000, 1'b1, 1'b1, 16'h6655},  // R3
        {2'b10, 18'h3FE00, 16'hFFFF, 1'b0, 1'b0, 16'h0000},  // R4 outside window
        {2'b00, 18'h3FF00, 16'h0000, 1'b1, 1'b1, 16'h1234},  // R4 untouched
        {2'b01, 18'h3FF0E, 16'h0000, 1'b1, 1'b1, 16'h0000},  // R6 rmw read
        {2'b10, 18'h3FF0E, 16'h0F0F, 1'b1, 1'b0, 16'h0000},  // R6 completing write
        {2'b01, 18'h3FF0E, 16'h0000, 1'b1, 1'b1, 16'h0F0F},  // R6 released
        {2'b11, 18'h3FF0F, 16'hA5FF, 1'b1, 1'b0, 16'h0000},  // R6 byte completes
        {2'b00, 18'h3FF0E, 16'h0000, 1'b1, 1'b1, 16'hA50F}   // R3/R6
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One bus cycle; checks the R5 strobe timing when acknowledged.
    task automatic bus_cycle(input logic [1:0] c, input logic [17:0] a, input logic [15:0] d,
                             output bit acked, output logic [15:0] rd);
        acked = 1'b0;
        @(negedge clk);
        ctl = c; addr = a; wdata = d; msync = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (ssync) begin
                acked = 1'b1;
                break;
            end
        end
        rd = rdata;
        if (acked) begin
            @(negedge clk);
            chk("R5 hold while msync high", 32'(ssync), 32'd1);
            msync = 1'b0;
            @(negedge clk);
            chk("R5 drop after msync low", 32'(ssync), 32'd0);
        end else begin
            msync = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        bit          ack;
        logic [15:0] rd;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 ssync after reset", 32'(ssync), 32'd0);
        chk("R10 rdata after reset", 32'(rdata), 32'h0);
        bus_cycle(2'b00, 18'h3FF04, 16'h0, ack, rd);
        chk("R10 stored word zero", 32'(rd), 32'h0);

        for (int v = 0; v < NV; v++) begin
            bus_cycle(VECS[v][53:52], VECS[v][51:34], VECS[v][33:18], ack, rd);
            chk($sformatf("R4/R5 vector %0d ack", v), 32'(ack), 32'(VECS[v][17]));
            if (VECS[v][16]) chk($sformatf("R1/R3/R6 vector %0d rdata", v), 32'(rd), 32'(VECS[v][15:0]));
        end

        // R8: power warnings suppress writes but still acknowledge
        ac_low = 1'b1;
        bus_cycle(2'b10, 18'h3FF00, 16'hFFFF, ack, rd);
        chk("R8 ac_low write acked", 32'(ack), 32'd1);
        ac_low = 1'b0;
        dc_low = 1'b1;
        bus_cycle(2'b11, 18'h3FF01, 16'hFFFF, ack, rd);
        chk("R8 dc_low byte write acked", 32'(ack), 32'd1);
        dc_low = 1'b0;
        bus_cycle(2'b00, 18'h3FF00, 16'h0, ack, rd);
        chk("R8 word unchanged", 32'(rd), 32'h1234);

        // R7/R9: lock hold and release by bus init
        bus_cycle(2'b01, 18'h3FF06, 16'h0, ack, rd);
        chk("R6 rmw read acked", 32'(ack), 32'd1);
        @(negedge clk);
        ctl = 2'b01; addr = 18'h3FF06; msync = 1'b1;
        repeat (6) @(negedge clk);
        chk("R7 held rmw not acked", 32'(ssync), 32'd0);
        bus_init = 1'b1;
        @(negedge clk);
        bus_init = 1'b0;
        ack = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ssync) begin
                ack = 1'b1;
                break;
            end
        end
        chk("R9 held rmw released by init", 32'(ack), 32'd1);
        chk("R9 rmw data", 32'(rdata), 32'h0);
        msync = 1'b0;
        @(negedge clk);
        chk("R5 drop after held cycle", 32'(ssync), 32'd0);
        bus_cycle(2'b10, 18'h3FF06, 16'h1111, ack, rd);
        bus_cycle(2'b01, 18'h3FF06, 16'h0, ack, rd);
        chk("R6 relock after completing write", 32'(ack), 32'd1);
        chk("R6 read of completed word", 32'(rd), 32'h1111);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule